// File: doc/BRIEF.md
# Pipelined Dot-Product Engine

The engine takes two integer vectors as a stream of element pairs and returns their inner product as one scalar. Each accepted pair goes into a four-stage multiplier. Four clocks later its product reaches the input of a four-stage adder. The adder's own output is routed back to its second operand, so the adder pipeline is the accumulator. Up to four running sums travel round it at once. With a stream that has no gaps, slot k collects products k, k+4, k+8 and so on. While a slot is still empty, its feedback operand reads as zero.

When the pair flagged `in_last` has been accepted, input is closed. The multiplier drains into the adder. The four running sums are then pulled out into lane registers and folded pairwise through the same adder: four values become two, and two become one. The final value is presented on `out_result` together with a one-cycle `out_done`. Operands are 16-bit signed. The accumulation is 40-bit signed, which is enough for 256 elements of any value.

The controller is a state machine with these states and transitions:
- `ST_IDLE` goes to `ST_ACCUM` on a pair that is not last, or to `ST_DRAIN` on a last pair.
- `ST_ACCUM` goes to `ST_DRAIN` on the last pair.
- `ST_DRAIN` goes to `ST_COLLECT` once the multiplier holds no valid product.
- `ST_COLLECT` spends four cycles moving one adder slot per cycle into a lane register, then goes to `ST_REDUCE`.
- `ST_REDUCE` issues pair sums and captures their results level by level, then goes to `ST_DONE` when the single final sum is captured.
- `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

Top module: `dotp_engine`

## Requirements
- R1: During and right after reset, `in_ready` is 1, `out_done` is 0 and `out_result` is 0.
- R2: For a vector sent without gaps, `out_result` equals the exact sum of the signed products a_i*b_i, written as 40-bit two's complement.
- R3: A vector of 256 elements, each with a = b = -32768, yields exactly 2^38 (274877906944). Nothing is lost to overflow.
- R4: Cycles with `in_valid` low between elements of one vector do not change the result.
- R5: `in_ready` is low from the cycle after the last element is accepted up to and including the `out_done` cycle. Pairs offered while `in_ready` is low are ignored: they affect neither this result nor the next vector.
- R6: `out_done` is high for exactly one cycle per vector. `out_result` changes only in a cycle where `out_done` is high, and holds its value until the next one.
- R7: With default parameters, `out_done` is seen high at most 28 clock cycles after the edge that accepted the last element.
- R8: A one-element vector, whose first pair carries `in_last`, yields that pair's product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An element pair is offered |
| in_ready | output | 1 | The engine accepts a pair this cycle |
| in_last | input | 1 | The offered pair ends the vector |
| in_a | input | 16 | Element of vector A, signed |
| in_b | input | 16 | Element of vector B, signed |
| out_done | output | 1 | One-cycle pulse: `out_result` holds a new dot product |
| out_result | output | 40 | Dot product, signed |

## Verification
The hardest case to reach from the ports is a product that lands in an adder slot where no sum is circulating while other slots are busy. A stream with gaps creates this, because the slots then no longer follow element order. The bench sends a vector with two idle cycles after every element and one with single gaps, then compares each against the plain sum. It also offers large last-flagged pairs during the whole drain and reduction. It then checks that the result and the following vector are unaffected. The 256-element extreme vector pushes every partial sum close to the top of its range.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACCUM   = 3'd1,
        ST_DRAIN   = 3'd2,
        ST_COLLECT = 3'd3,
        ST_REDUCE  = 3'd4,
        ST_DONE    = 3'd5
    } dp_state_e;

endpackage

// File: rtl/dotp_mul_pipe.sv
module dotp_mul_pipe #(
    parameter int OP_W = 16,
    parameter int LAT  = 4,
    parameter int PW   = 2 * OP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [OP_W-1:0] in_a,
    input  logic signed [OP_W-1:0] in_b,
    output logic                 out_vld,
    output logic signed [PW-1:0] out_prod,
    output logic                 busy
);

    logic [LAT-1:0]        vld_q;
    logic signed [PW-1:0]  prod_q [LAT];
    logic signed [PW-1:0]  prod_d;

    // Full-width signed product; the true value always fits in PW bits.
    assign prod_d = $signed({{OP_W{in_a[OP_W-1]}}, in_a}) *
                    $signed({{OP_W{in_b[OP_W-1]}}, in_b});

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[LAT-2:0], in_vld};
    end

    always_ff @(posedge clk) begin
        prod_q[0] <= prod_d;
        for (int i = 1; i < LAT; i++) prod_q[i] <= prod_q[i-1];
    end

    assign out_vld  = vld_q[LAT-1];
    assign out_prod = prod_q[LAT-1];
    assign busy     = |vld_q;

endmodule

// File: rtl/dotp_add_pipe.sv
module dotp_add_pipe #(
    parameter int W   = 40,
    parameter int LAT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_x,
    input  logic signed [W-1:0] in_y,
    output logic                out_vld,
    output logic signed [W-1:0] out_sum
);

    logic [LAT-1:0]       vld_q;
    logic signed [W-1:0]  sum_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[LAT-2:0], in_vld};
    end

    always_ff @(posedge clk) begin
        sum_q[0] <= in_x + in_y;
        for (int i = 1; i < LAT; i++) sum_q[i] <= sum_q[i-1];
    end

    assign out_vld = vld_q[LAT-1];
    assign out_sum = sum_q[LAT-1];

endmodule

// File: rtl/dotp_ctrl.sv
module dotp_ctrl
    import dotp_pkg::*;
#(
    parameter int LANES = 4,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_fire,
    input  logic          in_last,
    input  logic          mul_busy,
    input  logic          add_out_vld,
    output logic          in_ready,
    output logic          recirc_en,
    output logic          cap_en,
    output logic [IW-1:0] cap_idx,
    output logic          iss_en,
    output logic [IW-1:0] iss_idx,
    output logic          fin,
    output logic          done_o
);

    localparam logic [IW:0]   LANES_W = (IW+1)'(LANES);
    localparam logic [IW-1:0] COL_END = IW'(LANES - 1);
    localparam logic [IW:0]   TWO     = (IW+1)'(2);

    dp_state_e     state_q, state_d;
    logic [IW-1:0] col_cnt, iss_cnt, cap_cnt;
    logic [IW:0]   live;
    logic [IW:0]   half;
    logic          lvl_end;

    assign half    = live >> 1;
    assign lvl_end = (state_q == ST_REDUCE) && add_out_vld &&
                     ({1'b0, cap_cnt} == half - 1'b1);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (in_fire) state_d = in_last ? ST_DRAIN : ST_ACCUM;
            ST_ACCUM:   if (in_fire && in_last) state_d = ST_DRAIN;
            ST_DRAIN:   if (!mul_busy) state_d = ST_COLLECT;
            ST_COLLECT: if (col_cnt == COL_END) state_d = ST_REDUCE;
            ST_REDUCE:  if (lvl_end && live == TWO) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        recirc_en = 1'b0;
        cap_en    = 1'b0;
        cap_idx   = cap_cnt;
        iss_en    = 1'b0;
        iss_idx   = iss_cnt;
        fin       = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:    in_ready = 1'b1;
            ST_ACCUM: begin
                in_ready  = 1'b1;
                recirc_en = 1'b1;
            end
            ST_DRAIN:   recirc_en = 1'b1;
            ST_COLLECT: begin
                cap_en  = 1'b1;
                cap_idx = col_cnt;
            end
            ST_REDUCE: begin
                cap_en = add_out_vld;
                iss_en = ({1'b0, iss_cnt} < half);
                fin    = lvl_end && (live == TWO);
            end
            ST_DONE:    done_o = 1'b1;
        endcase
    end

    // sequencing counters
    always_ff @(posedge clk) begin
        if (rst) begin
            col_cnt <= '0;
            iss_cnt <= '0;
            cap_cnt <= '0;
            live    <= LANES_W;
        end else begin
            if (state_q == ST_COLLECT) col_cnt <= col_cnt + 1'b1;
            else                       col_cnt <= '0;
            if (state_q == ST_REDUCE) begin
                if (lvl_end) begin
                    live    <= half;
                    iss_cnt <= '0;
                    cap_cnt <= '0;
                end else begin
                    if (iss_en)      iss_cnt <= iss_cnt + 1'b1;
                    if (add_out_vld) cap_cnt <= cap_cnt + 1'b1;
                end
            end else begin
                iss_cnt <= '0;
                cap_cnt <= '0;
                live    <= LANES_W;
            end
        end
    end

endmodule

// File: rtl/dotp_engine.sv
module dotp_engine
    import dotp_pkg::*;
#(
    parameter int OP_W    = 16,
    parameter int ACC_W   = 40,
    parameter int MUL_LAT = 4,
    parameter int ADD_LAT = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_last,
    input  logic signed [OP_W-1:0]  in_a,
    input  logic signed [OP_W-1:0]  in_b,
    output logic                    out_done,
    output logic signed [ACC_W-1:0] out_result
);

    // ADD_LAT is the number of interleaved partial sums: a power of two, 4 or more.
    localparam int PROD_W = 2 * OP_W;
    localparam int LANES  = ADD_LAT;
    localparam int IDX_W  = $clog2(LANES);

    logic                     in_fire;
    logic                     mul_vld, mul_busy;
    logic signed [PROD_W-1:0] mul_prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic                     add_in_vld, add_out_vld;
    logic signed [ACC_W-1:0]  add_x, add_y, add_out, add_keep;
    logic                     recirc_en, cap_en, iss_en, fin;
    logic [IDX_W-1:0]         cap_idx, iss_idx, pair_lo, pair_hi;
    logic signed [ACC_W-1:0]  lane_q [LANES];
    logic signed [ACC_W-1:0]  result_q;

    assign in_fire = in_valid && in_ready;

    dotp_mul_pipe #(.OP_W(OP_W), .LAT(MUL_LAT), .PW(PROD_W)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_fire),
        .in_a     (in_a),
        .in_b     (in_b),
        .out_vld  (mul_vld),
        .out_prod (mul_prod),
        .busy     (mul_busy)
    );

    assign prod_ext = {{(ACC_W-PROD_W){mul_prod[PROD_W-1]}}, mul_prod};

    dotp_ctrl #(.LANES(LANES), .IW(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_fire     (in_fire),
        .in_last     (in_last),
        .mul_busy    (mul_busy),
        .add_out_vld (add_out_vld),
        .in_ready    (in_ready),
        .recirc_en   (recirc_en),
        .cap_en      (cap_en),
        .cap_idx     (cap_idx),
        .iss_en      (iss_en),
        .iss_idx     (iss_idx),
        .fin         (fin),
        .done_o      (out_done)
    );

    assign pair_lo  = {iss_idx[IDX_W-2:0], 1'b0};
    assign pair_hi  = {iss_idx[IDX_W-2:0], 1'b1};
    assign add_keep = add_out_vld ? add_out : '0;

    // Adder operand select: running accumulation, or pairwise reduction.
    always_comb begin
        add_in_vld = 1'b0;
        add_x      = '0;
        add_y      = '0;
        if (recirc_en) begin
            add_in_vld = mul_vld || add_out_vld;
            add_x      = mul_vld ? prod_ext : '0;
            add_y      = add_keep;
        end else if (iss_en) begin
            add_in_vld = 1'b1;
            add_x      = lane_q[pair_lo];
            add_y      = lane_q[pair_hi];
        end
    end

    dotp_add_pipe #(.W(ACC_W), .LAT(ADD_LAT)) u_add (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (add_in_vld),
        .in_x    (add_x),
        .in_y    (add_y),
        .out_vld (add_out_vld),
        .out_sum (add_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
        end else if (cap_en) begin
            lane_q[cap_idx] <= add_keep;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      result_q <= '0;
        else if (fin) result_q <= add_out;
    end

    assign out_result = result_q;

endmodule

// File: rtl/dotp_engine_chk.sv
module dotp_engine_chk #(
    parameter int ACC_W   = 40,
    parameter int MUL_LAT = 4,
    parameter int ADD_LAT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             out_done,
    input logic [ACC_W-1:0] out_result
);

    localparam int BOUND = MUL_LAT + 4 * ADD_LAT + 8;

    logic [7:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)                              lat_cnt <= '0;
        else if (in_valid && in_ready && in_last) lat_cnt <= 8'd1;
        else if (lat_cnt != 8'd0 && lat_cnt != 8'hff) lat_cnt <= lat_cnt + 8'd1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!out_done && in_ready && out_result == '0));

    p_closed_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready);

    p_done_closed_r5: assert property (@(posedge clk) disable iff (rst)
        out_done |-> !in_ready);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> $stable(out_result));

    p_done_latency_r7: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (lat_cnt != 8'd0 && int'(lat_cnt) <= BOUND + 1));

endmodule

bind dotp_engine dotp_engine_chk #(
    .ACC_W   (ACC_W),
    .MUL_LAT (MUL_LAT),
    .ADD_LAT (ADD_LAT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_last    (in_last),
    .out_done   (out_done),
    .out_result (out_result)
);

// File: tb/dotp_engine_test.sv
`timescale 1ns/1ps
module dotp_engine_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic               in_last = 1'b0;
    logic signed [15:0] in_a = '0;
    logic signed [15:0] in_b = '0;
    logic               out_done;
    logic signed [39:0] out_result;

    int  n_chk = 0;
    int  n_err = 0;
    bit  all_done = 1'b0;

    always #2.5 clk = ~clk;

    dotp_engine uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_last    (in_last),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_done   (out_done),
        .out_result (out_result)
    );

    // {length, a start, a step, b start, b step, idle cycles after each element}
    localparam int VECS [6][6] = '{
        '{8,      1,   1,    1,  1, 0},
        '{5,     -3,   2,    7, -1, 0},
        '{16,   100, -13,  -50,  7, 0},
        '{9,  32767,   0, 32767,  0, 0},
        '{12,   -20,   3,   11,  5, 2},
        '{3,      5,   1,   -4,  2, 1}
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic run_vec(input int len, input int a0, input int da, input int b0,
                           input int db, input int gap, input bit junk, input string tag);
        longint exp_sum = 0;
        longint prev;
        int     k;
        bit     rdy_bad = 1'b0;
        for (int i = 0; i < len; i++) begin
            logic signed [15:0] a, b;
            a = 16'(a0 + i * da);
            b = 16'(b0 + i * db);
            exp_sum += longint'(a) * longint'(b);
            in_valid = 1'b1;
            in_a     = a;
            in_b     = b;
            in_last  = (i == len - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            if (i != len - 1)
                for (int g = 0; g < gap; g++) @(negedge clk);
        end
        k = 1;
        while (!out_done && k <= 60) begin
            if (in_ready) rdy_bad = 1'b1;
            if (junk) begin
                in_valid = 1'b1;
                in_last  = 1'b1;
                in_a     = 16'sh7fff;
                in_b     = -16'sh7fff;
            end
            @(negedge clk);
            k++;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (in_ready) rdy_bad = 1'b1;
        check(!rdy_bad, "R5 ready low while busy", longint'(rdy_bad), 0);
        check(out_done && k <= 28, "R7 done latency", k, 28);
        check(out_result == 40'(exp_sum), tag, longint'(out_result), exp_sum);
        prev = longint'(out_result);
        @(negedge clk);
        check(!out_done && longint'(out_result) == prev, "R6 single done, result held",
              longint'(out_result), prev);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1 ready in reset", longint'(in_ready), 1);
        check(out_done == 1'b0, "R1 done in reset", longint'(out_done), 0);
        check(out_result == '0, "R1 result in reset", longint'(out_result), 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready && !out_done && out_result == '0, "R1 state after reset",
              longint'(out_result), 0);

        // R2 / R4: table of vectors, the gapped ones checked under R4
        for (int v = 0; v < 6; v++)
            run_vec(VECS[v][0], VECS[v][1], VECS[v][2], VECS[v][3], VECS[v][4],
                    VECS[v][5], 1'b0, (VECS[v][5] != 0) ? "R4 gapped result" : "R2 result");

        // R8: one-element vector
        run_vec(1, -7, 0, 300, 0, 0, 1'b0, "R8 single element");

        // R3: 256 extreme elements, exact 2^38
        run_vec(256, -32768, 0, -32768, 0, 0, 1'b0, "R3 extreme accumulation");

        // R5: pairs offered while closed are ignored, here and in the next vector
        run_vec(6, 9, -4, 2, 3, 0, 1'b1, "R5 result with ignored input");
        run_vec(4, 1, 1, -1, -1, 0, 1'b0, "R5 next vector clean");

        all_done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule